// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns level interrupt lines into posted interrupt messages. Software reaches its redirection table through two registers: an index register, and a data window that reads or writes the table word the index points at. Each interrupt input owns two table words. The first is a control word holding the vector, the trigger and polarity flags and a mask bit. The second is a destination word that holds a processor address in a packed form.

When an unmasked input with a valid destination rises, the block sets the pending bit picked by the low bits of the vector. If that bit was clear before, the block queues a message. The message is a 64-bit address, made by unpacking the destination and setting every upper bit, with the 6-bit vector as its 32-bit data. Messages leave one at a time over a valid/ready handshake. A write to the end-of-interrupt register clears the pending bits of all inputs whose vector equals the written value.

Top module: `irc_redirect`

## Requirements
- R1: After reset, no message is pending. Window index 1 reads 0x00200001: the entry capacity of 32 sits in bits 31:16 and the revision 1 in the low bits. For input i, the control word (index 0x10+2i) reads 0x1A000 + i + 2, which is mask bit 16, level bit 15, active-low bit 13 and vector i+2. The destination word (index 0x11+2i) reads 0xA0FF0000.
- R2: The index register sits at offset 0x800 and reads back what was written. The data window sits at offset 0x810 and reads back the value last written to the table word the index selects.
- R3: A window access whose index is 32 or more returns rsp_err and changes nothing. The same holds for any offset other than 0x800, 0x810 and 0x840.
- R4: A rising edge on input i produces one message when control bit 16 is clear, the destination fields are not both zero and the selected pending bit was clear. For a destination word d, msg_addr is {32'hFFFFFFFF, 4'hF, d[23:16], d[31:24], 12'h0} and msg_data is the control word's bits 5:0.
- R5: A rising edge on an input whose control bit 16 is set sends no message.
- R6: The pending bit is picked by vector bits 2:0. A rising edge that selects a bit already set sends no message.
- R7: A falling edge on an input clears the pending bit its vector selects, so the next rising edge sends a new message.
- R8: A write of v to offset 0x840 clears the pending bit of every input whose vector bits 5:0 equal v[5:0].
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold. Messages queued together leave in order of rising pending bit index, one per accepted handshake.
- R10: An input whose destination word has bits 31:16 all zero sends no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the same cycle as the read |
| rsp_err | output | 1 | Unmapped offset or window index out of range |
| irq_in | input | N_IN | Level interrupt inputs |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload (vector) |

## Verification
Directed sequences cover four cases that separate the pending-bit rules. The first is two inputs that share one pending bit, which shows that the bit is tested before a message is sent. The second is an end-of-interrupt write followed by a rising edge on a third input that maps to the same bit, which shows that the clear is done by vector match. The third is a drop and rise of the same input, which shows that a falling edge clears the bit. The fourth is a zero destination, which shows the destination check. A back-pressured pair of inputs shows the hold and ordering rules. Random vectors, control flags and destination words on random inputs check the unpacking of the address field by field against a bench model.

// File: rtl/irc_pkg.sv
// irc_pkg: shared offsets, control-word bit positions and destination
// packing helpers for the interrupt redirection controller.
// Assumes 32-bit registers placed on 8-byte aligned offsets.
package irc_pkg;

    localparam logic [11:0] OFF_INDEX  = 12'h800;
    localparam logic [11:0] OFF_WINDOW = 12'h810;
    localparam logic [11:0] OFF_EOI    = 12'h840;

    localparam int CW_MASK_BIT  = 16;
    localparam int CW_LEVEL_BIT = 15;
    localparam int CW_LOW_BIT   = 13;
    localparam int CW_LOWPRI_BIT = 8;
    localparam int VEC_W        = 6;
    localparam int ENTRY_BASE   = 16;

    localparam logic [31:0] CW_RESET_FLAGS =
        (32'd1 << CW_MASK_BIT) | (32'd1 << CW_LEVEL_BIT) | (32'd1 << CW_LOW_BIT);

    // Pack a processor address into the stored destination format.
    function automatic logic [31:0] pack_dest(input logic [31:0] a);
        return ((a & 32'h0FF0_0000) >> 4) | ((a & 32'h000F_F000) << 12);
    endfunction

    // Unpack a stored destination word into a processor address.
    function automatic logic [31:0] unpack_dest(input logic [31:0] d);
        return ((d << 4) & 32'h0FF0_0000) | ((d >> 12) & 32'h000F_F000)
               | 32'hF000_0000;
    endfunction

endpackage

// File: rtl/irc_regs.sv
// irc_regs: index register, redirection table and data window decode.
// Reads are combinational; writes land on the next clock edge.
// Assumes the per-input entries (0x10 + 2*i, 0x11 + 2*i) fit in the table.
module irc_regs
    import irc_pkg::*;
#(
    parameter int          N_IN      = 8,
    parameter int          TBL_DEPTH = 32,
    parameter int          ADDR_W    = 12,
    parameter int          REVISION  = 1,
    parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [31:0]            req_wdata,
    output logic [31:0]            rsp_rdata,
    output logic                   rsp_err,
    output logic                   eoi_valid,
    output logic [VEC_W-1:0]       eoi_vec,
    output logic [N_IN-1:0][31:0]  ctl_words,
    output logic [N_IN-1:0][31:0]  dst_words
);
    localparam int IDX_W = $clog2(TBL_DEPTH);

    logic [31:0]             index_q;
    logic [TBL_DEPTH-1:0][31:0] tbl_q;
    logic [ADDR_W-1:0]       slot_addr;
    logic                    hit_index, hit_window, hit_eoi, in_range;
    logic                    wr_index, wr_window;
    logic [IDX_W-1:0]        idx;

    // Reset value of table word k.
    function automatic logic [31:0] reset_word(input int k);
        if (k >= ENTRY_BASE && k < ENTRY_BASE + 2 * N_IN) begin
            if (((k - ENTRY_BASE) % 2) == 0)
                return CW_RESET_FLAGS | 32'(((k - ENTRY_BASE) / 2) + 2);
            else
                return pack_dest(CPU_ADDR);
        end
        return 32'd0;
    endfunction

    // Decode the aligned register slot addressed by the request.
    always_comb begin
        slot_addr  = {req_addr[ADDR_W-1:3], 3'b000};
        hit_index  = (slot_addr == ADDR_W'(OFF_INDEX));
        hit_window = (slot_addr == ADDR_W'(OFF_WINDOW));
        hit_eoi    = (slot_addr == ADDR_W'(OFF_EOI));
        in_range   = (index_q < 32'(TBL_DEPTH));
        idx        = index_q[IDX_W-1:0];
        wr_index   = req_valid && req_write && hit_index;
        wr_window  = req_valid && req_write && hit_window && in_range;
    end

    // Index register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= 32'd0;
        else if (wr_index) index_q <= req_wdata;
    end

    // Table storage with per-word reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_DEPTH; k++) tbl_q[k] <= reset_word(k);
        end else if (wr_window) begin
            tbl_q[idx] <= req_wdata;
        end
    end

    // Read data and error response.
    always_comb begin
        rsp_rdata = 32'd0;
        rsp_err   = 1'b0;
        if (req_valid) begin
            if (hit_index) begin
                rsp_rdata = req_write ? 32'd0 : index_q;
            end else if (hit_window) begin
                if (!in_range)           rsp_err   = 1'b1;
                else if (req_write)      rsp_rdata = 32'd0;
                else if (index_q == 32'd1)
                    rsp_rdata = {16'(TBL_DEPTH), 16'(REVISION)};
                else                     rsp_rdata = tbl_q[idx];
            end else if (!hit_eoi) begin
                rsp_err = 1'b1;
            end
        end
    end

    // End-of-interrupt strobe toward the pending logic.
    always_comb begin
        eoi_valid = req_valid && req_write && hit_eoi;
        eoi_vec   = req_wdata[VEC_W-1:0];
    end

    // Per-input view of the table.
    for (genvar i = 0; i < N_IN; i++) begin : g_entry
        assign ctl_words[i] = tbl_q[ENTRY_BASE + 2 * i];
        assign dst_words[i] = tbl_q[ENTRY_BASE + 2 * i + 1];
    end

endmodule

// File: rtl/irc_pend.sv
// irc_pend: edge detection on the inputs, pending bits and the queue of
// messages waiting to leave. Pending bit = vector bits [SLOT_W-1:0].
// Assumes N_IN is a power of two; a set wins over a clear in one cycle.
module irc_pend
    import irc_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int SLOT_W = $clog2(N_IN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0]              irq_in,
    input  logic [N_IN-1:0][31:0]        ctl_words,
    input  logic [N_IN-1:0][31:0]        dst_words,
    input  logic                         eoi_valid,
    input  logic [VEC_W-1:0]             eoi_vec,
    input  logic [N_IN-1:0]              launch_oh,
    output logic [N_IN-1:0]              send_q,
    output logic [N_IN-1:0][SLOT_W-1:0]  src_q
);
    logic [N_IN-1:0]             irq_q, pend_q;
    logic [N_IN-1:0]             rise, fall, set_v, clr_v, fire;
    logic [N_IN-1:0][SLOT_W-1:0] src_n;

    // Edge detection against the previous input levels.
    always_comb begin
        rise = irq_in & ~irq_q;
        fall = ~irq_in & irq_q;
    end

    // Collect set and clear requests per pending bit; lowest input names the source.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        src_n = src_q;
        for (int i = N_IN - 1; i >= 0; i--) begin
            logic [SLOT_W-1:0] s;
            logic              ok;
            s  = ctl_words[i][SLOT_W-1:0];
            ok = !ctl_words[i][CW_MASK_BIT] && (dst_words[i][31:16] != 16'd0);
            if (rise[i] && ok) begin
                set_v[s] = 1'b1;
                if (!pend_q[s]) src_n[s] = SLOT_W'(i);
            end else if (rise[i] || fall[i]) begin
                clr_v[s] = 1'b1;
            end
            if (eoi_valid && ctl_words[i][VEC_W-1:0] == eoi_vec) clr_v[s] = 1'b1;
        end
        fire = set_v & ~pend_q;
    end

    // Input history, pending bits, send queue and message sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_q <= '0;
            send_q <= '0;
            src_q  <= '0;
        end else begin
            irq_q  <= irq_in;
            pend_q <= (pend_q & ~clr_v) | set_v;
            send_q <= (send_q & ~launch_oh) | fire;
            src_q  <= src_n;
        end
    end

endmodule

// File: rtl/irc_msg.sv
// irc_msg: picks the lowest queued pending bit and drives the outgoing
// message register over a valid/ready handshake. The message reads the
// source input's table entry at launch time.
module irc_msg
    import irc_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int SLOT_W = $clog2(N_IN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0]              send_q,
    input  logic [N_IN-1:0][SLOT_W-1:0]  src_q,
    input  logic [N_IN-1:0][31:0]        ctl_words,
    input  logic [N_IN-1:0][31:0]        dst_words,
    input  logic                         msg_ready,
    output logic [N_IN-1:0]              launch_oh,
    output logic                         msg_valid,
    output logic [63:0]                  msg_addr,
    output logic [31:0]                  msg_data
);
    logic [SLOT_W-1:0] pick;
    logic [SLOT_W-1:0] src;
    logic              any, can_load;

    // Lowest-index queued bit and launch decision.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int s = N_IN - 1; s >= 0; s--) begin
            if (send_q[s]) begin
                pick = SLOT_W'(s);
                any  = 1'b1;
            end
        end
        can_load  = !msg_valid || msg_ready;
        launch_oh = '0;
        if (any && can_load) launch_oh[pick] = 1'b1;
        src = src_q[pick];
    end

    // Outgoing message register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (any && can_load) begin
            msg_valid <= 1'b1;
            msg_addr  <= {32'hFFFF_FFFF, unpack_dest(dst_words[src])};
            msg_data  <= {{(32 - VEC_W){1'b0}}, ctl_words[src][VEC_W-1:0]};
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/irc_redirect.sv
// irc_redirect: top of the interrupt redirection controller. Ties the
// register file, pending logic and message output together.
// Assumes one register access per cycle and level inputs synchronous to clk.
module irc_redirect
    import irc_pkg::*;
#(
    parameter int          N_IN      = 8,
    parameter int          TBL_DEPTH = 32,
    parameter int          ADDR_W    = 12,
    parameter int          REVISION  = 1,
    parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [N_IN-1:0]   irq_in,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);
    localparam int SLOT_W = $clog2(N_IN);

    logic [N_IN-1:0][31:0]       ctl_words, dst_words;
    logic                        eoi_valid;
    logic [VEC_W-1:0]            eoi_vec;
    logic [N_IN-1:0]             send_q, launch_oh;
    logic [N_IN-1:0][SLOT_W-1:0] src_q;

    irc_regs #(
        .N_IN(N_IN), .TBL_DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W),
        .REVISION(REVISION), .CPU_ADDR(CPU_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .ctl_words(ctl_words), .dst_words(dst_words)
    );

    irc_pend #(.N_IN(N_IN), .SLOT_W(SLOT_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .ctl_words(ctl_words), .dst_words(dst_words),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
        .launch_oh(launch_oh), .send_q(send_q), .src_q(src_q)
    );

    irc_msg #(.N_IN(N_IN), .SLOT_W(SLOT_W)) u_msg (
        .clk(clk), .rst_n(rst_n), .send_q(send_q), .src_q(src_q),
        .ctl_words(ctl_words), .dst_words(dst_words),
        .msg_ready(msg_ready), .launch_oh(launch_oh),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

endmodule

// File: rtl/irc_redirect_chk.sv
// irc_redirect_chk: protocol checks on the ports of irc_redirect,
// attached through bind.
module irc_redirect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_err,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data
);
    // R3: an error response only answers an access.
    a_r3_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> req_valid);

    // R9: a stalled message keeps its valid and its contents.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R4: message address has its upper bits forced to ones.
    a_r4_addr_upper: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[63:28] == 36'hF_FFFF_FFFF);

    // R4: message payload carries a 6-bit vector only.
    a_r4_data_width: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_data[31:6] == 26'd0);

    // R4: the unpacked address is page aligned.
    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[11:0] == 12'd0);
endmodule

bind irc_redirect irc_redirect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_err(rsp_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_irc_redirect.sv
// sim_irc_redirect: directed and seeded random bench for irc_redirect.
module sim_irc_redirect;
    localparam int CLK_P = 10;
    localparam logic [11:0] A_IDX = 12'h800, A_WIN = 12'h810, A_EOI = 12'h840;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [7:0]  irq_in = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0, errors = 0;
    int cap_n = 0;
    logic [63:0] cap_addr [8];
    logic [31:0] cap_data [8];

    irc_redirect u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .irq_in(irq_in), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic logic [63:0] exp_addr(input logic [31:0] d);
        return {32'hFFFF_FFFF, 4'hF, d[23:16], d[31:24], 12'h000};
    endfunction

    function automatic logic [31:0] pack(input logic [31:0] a);
        return {a[19:12], a[27:20], 16'h0000};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #(CLK_P / 4);
        d = rsp_rdata; e = rsp_err;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic prog(input logic [31:0] idx, input logic [31:0] v);
        reg_wr(A_IDX, idx);
        reg_wr(A_WIN, v);
    endtask

    task automatic set_irq(input int i, input logic lvl);
        @(negedge clk);
        irq_in[i] = lvl;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Record every accepted message, sampled between edges.
    always @(negedge clk) begin
        #(CLK_P / 4);
        if (rst_n && msg_valid && msg_ready) begin
            if (cap_n < 8) begin
                cap_addr[cap_n] = msg_addr;
                cap_data[cap_n] = msg_data;
            end
            cap_n++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        void'($urandom(32'd2024));
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk); #(CLK_P / 4);
        chk("R1 msg_valid after reset", 64'(msg_valid), 64'd0);

        // R1: revision word and reset entries.
        prog(32'd1, 32'h0);
        reg_rd(A_WIN, rd, er);
        chk("R1 revision word", 64'(rd), 64'h0020_0001);
        for (int i = 0; i < 8; i++) begin
            reg_wr(A_IDX, 32'(16 + 2 * i));
            reg_rd(A_WIN, rd, er);
            chk("R1 control default", 64'(rd), 64'(32'h1A000 + 32'(i + 2)));
            reg_wr(A_IDX, 32'(17 + 2 * i));
            reg_rd(A_WIN, rd, er);
            chk("R1 destination default", 64'(rd), 64'h0000_0000_A0FF_0000);
        end

        // R2: index readback and window round trip.
        reg_wr(A_IDX, 32'h5);
        reg_rd(A_IDX, rd, er);
        chk("R2 index readback", 64'(rd), 64'h5);
        reg_wr(A_WIN, 32'hDEAD_BEEF);
        reg_rd(A_WIN, rd, er);
        chk("R2 window readback", 64'(rd), 64'hDEAD_BEEF);

        // R3: out-of-range index and unmapped offsets.
        reg_wr(A_IDX, 32'h20);
        reg_rd(A_WIN, rd, er);
        chk("R3 read beyond table err", 64'(er), 64'd1);
        reg_rd(12'h100, rd, er);
        chk("R3 unmapped offset err", 64'(er), 64'd1);
        reg_wr(A_IDX, 32'h1F);
        reg_rd(A_WIN, rd, er);
        chk("R3 last index no err", 64'(er), 64'd0);
        reg_wr(A_IDX, 32'h25);
        reg_wr(A_WIN, 32'h1234_5678);
        reg_wr(A_IDX, 32'h05);
        reg_rd(A_WIN, rd, er);
        chk("R3 wide-index write ignored", 64'(rd), 64'hDEAD_BEEF);

        // R5: default entries are masked.
        set_irq(3, 1'b1); wait_cyc(8);
        chk("R5 masked input silent", 64'(cap_n), 64'd0);
        set_irq(3, 1'b0); wait_cyc(2);

        // R4: directed message from input 0.
        prog(32'h10, 32'h05);
        set_irq(0, 1'b1); wait_cyc(8);
        chk("R4 one message", 64'(cap_n), 64'd1);
        chk("R4 address", cap_addr[0], 64'hFFFF_FFFF_FFFA_0000);
        chk("R4 data", 64'(cap_data[0]), 64'h05);

        // R6: second input on the same pending bit.
        prog(32'h12, 32'h0D);
        set_irq(1, 1'b1); wait_cyc(8);
        chk("R6 shared pending bit silent", 64'(cap_n), 64'd1);

        // R8: end-of-interrupt by vector frees the bit for input 2.
        reg_wr(A_EOI, 32'hC5);
        prog(32'h14, 32'h15);
        set_irq(2, 1'b1); wait_cyc(8);
        chk("R8 message after eoi", 64'(cap_n), 64'd2);
        chk("R8 data", 64'(cap_data[1]), 64'h15);

        // R7: falling edges clear, next rise sends again.
        set_irq(0, 1'b0); set_irq(1, 1'b0); set_irq(2, 1'b0); wait_cyc(3);
        set_irq(0, 1'b1); wait_cyc(8);
        chk("R7 resend after fall", 64'(cap_n), 64'd3);
        chk("R7 data", 64'(cap_data[2]), 64'h05);
        set_irq(0, 1'b0); wait_cyc(3);

        // R10: empty destination blocks the message.
        prog(32'h18, 32'h22);
        prog(32'h19, 32'h0000_1234);
        set_irq(4, 1'b1); wait_cyc(8);
        chk("R10 zero destination silent", 64'(cap_n), 64'd3);
        set_irq(4, 1'b0); wait_cyc(3);

        // R9: back-pressure, hold and order.
        prog(32'h1A, 32'h31);
        prog(32'h1C, 32'h3A);
        cap_n = 0;
        @(negedge clk); msg_ready = 1'b0; irq_in[6] = 1'b1; irq_in[5] = 1'b1;
        wait_cyc(6);
        #(CLK_P / 4);
        chk("R9 none accepted while stalled", 64'(cap_n), 64'd0);
        chk("R9 valid held", 64'(msg_valid), 64'd1);
        chk("R9 first in line", 64'(msg_data), 64'h31);
        @(negedge clk); msg_ready = 1'b1;
        wait_cyc(8);
        chk("R9 both delivered", 64'(cap_n), 64'd2);
        chk("R9 order first", 64'(cap_data[0]), 64'h31);
        chk("R9 order second", 64'(cap_data[1]), 64'h3A);
        set_irq(5, 1'b0); set_irq(6, 1'b0); wait_cyc(3);

        // R4: random vectors, flags and destinations.
        for (int n = 0; n < 24; n++) begin
            int unsigned i;
            logic [31:0] cw, dw;
            i  = $urandom % 8;
            cw = ($urandom & 32'h0000_A100) | ($urandom % 64);
            dw = $urandom | 32'h0100_0000;
            prog(32'(16 + 2 * i), cw);
            prog(32'(17 + 2 * i), dw);
            cap_n = 0;
            set_irq(int'(i), 1'b1); wait_cyc(8);
            chk("R4 random count", 64'(cap_n), 64'd1);
            chk("R4 random address", cap_addr[0], exp_addr(dw));
            chk("R4 random data", 64'(cap_data[0]), 64'(cw[5:0]));
            set_irq(int'(i), 1'b0); wait_cyc(3);
        end
        chk("R4 pack model", 64'(pack(32'hFFFA_0000)), 64'hA0FF_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule